// File: doc/BRIEF.md
# Sample Period Timer with Interrupt Divider

This block produces the periodic tick that paces the draining of a pair of audio sample queues, and counts those ticks down to raise a processor interrupt once every N periods. The period length comes from a 12-bit cycle setting. The divide ratio comes from a 4-bit field in a 16-bit control word. When a control bit allows it, each interrupt can also fire a one-cycle request to a DMA engine, which then refills the queues.

Software writes the cycle and control settings. Each write is announced by a one-cycle strobe, and the new value is already present on the setting input in the strobe cycle. The interrupt stays pending until the processor acknowledges it. The DMA request does not depend on the pending flag, so the refill path keeps running while an interrupt is still waiting.

Top module: `smp_tick_irq_div`

## Requirements
- R1: The tick period in clocks is P = (cyc_cfg − 1) mod 4096. When P is 0, which happens for a setting of 1, `tick` never rises and no interrupt or DMA request is raised.
- R2: The period counter starts from zero on reset and in every cycle where `cyc_wr` is high. `tick` is low in a `cyc_wr` cycle. `tick` is high during the P-th cycle after a reset or write, and then once every P cycles.
- R3: The divide ratio is N = ((ctl_cfg[11:8] − 1) mod 16) + 1, so a field of 0 gives N = 16.
- R4: Every N-th counted tick is an expiry. `irq_pend` is high from the clock edge that ends the expiry cycle.
- R5: In a cycle where `ctl_wr` is high, the divider reloads N from the `ctl_cfg` value present in that cycle. A tick in the same cycle is not counted and cannot expire.
- R6: If ctl_cfg[7] is 1 in an expiry cycle, `dreq` is high for exactly the following cycle. This holds whether or not an interrupt is already pending. If ctl_cfg[7] is 0, `dreq` stays low.
- R7: Once set, `irq_pend` stays high until it is acknowledged. An expiry while it is pending leaves it high and does not queue a second interrupt.
- R8: `irq_ack` clears `irq_pend` at the next clock edge. If an expiry falls in the same cycle as the acknowledge, the new interrupt wins and `irq_pend` stays high.
- R9: Synchronous active-low reset clears `irq_pend` and `dreq`, zeroes the period counter and loads the divider with N computed from the `ctl_cfg` value present during reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cyc_cfg | input | 12 | Cycle setting; period is this minus one |
| ctl_cfg | input | 16 | Control word; bits 11:8 divide ratio, bit 7 DMA request enable |
| cyc_wr | input | 1 | Strobe: cycle setting written this cycle |
| ctl_wr | input | 1 | Strobe: control word written this cycle |
| irq_ack | input | 1 | Interrupt acknowledge |
| tick | output | 1 | High for one cycle at the end of each period |
| irq_pend | output | 1 | Sticky interrupt-pending flag |
| dreq | output | 1 | One-cycle DMA request pulse |

## Verification
Two pairs of events can fall in the same cycle. An acknowledge can meet a divider expiry, and a control write can meet a tick. Both pairs are provoked by running a period of one clock with a divide ratio of one, so that every cycle ticks and expires. Strobes and acknowledges are then applied in many cycles, both in a directed way and at random. A behavioural model gives the final pending state and divider phase for each pair: the new interrupt wins over the acknowledge, and the reload wins over the tick. The model is compared with the outputs in every cycle, so a wrong priority shows up as a divergence in `irq_pend` or in the timing of a later expiry.

// File: rtl/smpt_pkg.sv
// Package: shared widths and field positions of the sample period timer.
// Assumes the control word carries the divide field and the DMA enable at
// the positions given here. The divider and the bench both decode them.
package smpt_pkg;
    localparam int CYC_W    = 12;  // width of the cycle setting
    localparam int CTL_W    = 16;  // width of the control word
    localparam int DIV_W    = 4;   // width of the divide-ratio field
    localparam int DIV_LSB  = 8;   // lowest bit of the divide-ratio field
    localparam int DMA_BIT  = 7;   // DMA request enable bit
endpackage

// File: rtl/smpt_period.sv
// Module: smpt_period
// Counts clocks and emits a one-cycle tick every P = cyc_cfg - 1 clocks
// (modulo 2**CYC_W). When P is zero the counter is held and no tick is made.
// Assumes cyc_cfg already carries the new value in the cycle of cyc_wr.
module smpt_period #(
    parameter int CYC_W = smpt_pkg::CYC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CYC_W-1:0] cyc_cfg,
    input  logic             cyc_wr,
    output logic             tick
);
    localparam logic [CYC_W-1:0] ONE = CYC_W'(1);

    logic [CYC_W-1:0] period;
    logic [CYC_W-1:0] last;
    logic [CYC_W-1:0] cnt_q;
    logic             run;
    logic             at_end;

    // Decode period and terminal count from the setting
    always_comb begin
        period = cyc_cfg - ONE;
        last   = period - ONE;
        run    = (period != '0);
        at_end = (cnt_q >= last);
    end

    // Tick when the count reaches the end, except in a restart cycle
    assign tick = run && !cyc_wr && at_end;

    // Advance the count, restarting on a write, a wrap or a disable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cyc_wr || !run || at_end) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + ONE;
        end
    end
endmodule

// File: rtl/smpt_divider.sv
// Module: smpt_divider
// Counts ticks down from N = ((field - 1) mod 2**DIV_W) + 1. On reaching
// the last tick it reloads and signals an expiry. The expiry sets a
// sticky pending flag and, if enabled, a one-cycle DMA request.
// Assumes ctl_cfg already carries the new value in the cycle of ctl_wr.
// A control write takes priority over a tick in the same cycle, and an
// expiry takes priority over an acknowledge.
module smpt_divider #(
    parameter int CTL_W   = smpt_pkg::CTL_W,
    parameter int DIV_W   = smpt_pkg::DIV_W,
    parameter int DIV_LSB = smpt_pkg::DIV_LSB,
    parameter int DMA_BIT = smpt_pkg::DMA_BIT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CTL_W-1:0] ctl_cfg,
    input  logic             ctl_wr,
    input  logic             tick,
    input  logic             irq_ack,
    output logic             irq_pend,
    output logic             dreq
);
    localparam int CNT_W = DIV_W + 1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [DIV_W-1:0] field;
    logic [DIV_W-1:0] field_m1;
    logic [CNT_W-1:0] ratio;
    logic [CNT_W-1:0] left_q;
    logic             expire;
    logic             dma_en;
    logic             pend_q;
    logic             dreq_q;
    logic             unused_ctl;

    // Decode divide ratio; a zero field wraps to the full range
    always_comb begin
        field    = ctl_cfg[DIV_LSB +: DIV_W];
        field_m1 = field - DIV_W'(1);
        ratio    = {1'b0, field_m1} + CNT_ONE;
        dma_en   = ctl_cfg[DMA_BIT];
    end

    assign unused_ctl = ^{ctl_cfg};

    // An expiry is a counted tick on the last remaining count
    assign expire = tick && !ctl_wr && (left_q == CNT_ONE);

    // Remaining-tick counter: reload on write or expiry, else count ticks
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q <= ratio;
        end else if (ctl_wr || expire) begin
            left_q <= ratio;
        end else if (tick) begin
            left_q <= left_q - CNT_ONE;
        end
    end

    // Sticky pending flag: set by expiry, cleared by acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else begin
            pend_q <= expire || (pend_q && !irq_ack);
        end
    end

    // One-cycle DMA request after each enabled expiry
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dreq_q <= 1'b0;
        end else begin
            dreq_q <= expire && dma_en;
        end
    end

    assign irq_pend = pend_q;
    assign dreq     = dreq_q;
endmodule

// File: rtl/smp_tick_irq_div.sv
// Module: smp_tick_irq_div
// Top of the sample period timer: a period counter that makes the queue
// drain tick, followed by a divider that turns every N-th tick into an
// interrupt and an optional DMA request.
// Assumes one clock domain and a synchronous active-low reset.
module smp_tick_irq_div #(
    parameter int CYC_W   = smpt_pkg::CYC_W,
    parameter int CTL_W   = smpt_pkg::CTL_W,
    parameter int DIV_W   = smpt_pkg::DIV_W,
    parameter int DIV_LSB = smpt_pkg::DIV_LSB,
    parameter int DMA_BIT = smpt_pkg::DMA_BIT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CYC_W-1:0] cyc_cfg,
    input  logic [CTL_W-1:0] ctl_cfg,
    input  logic             cyc_wr,
    input  logic             ctl_wr,
    input  logic             irq_ack,
    output logic             tick,
    output logic             irq_pend,
    output logic             dreq
);
    logic tick_w;

    // Period counter
    smpt_period #(.CYC_W(CYC_W)) i_period (
        .clk     (clk),
        .rst_n   (rst_n),
        .cyc_cfg (cyc_cfg),
        .cyc_wr  (cyc_wr),
        .tick    (tick_w)
    );

    // Interrupt divider
    smpt_divider #(
        .CTL_W   (CTL_W),
        .DIV_W   (DIV_W),
        .DIV_LSB (DIV_LSB),
        .DMA_BIT (DMA_BIT)
    ) i_divider (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl_cfg  (ctl_cfg),
        .ctl_wr   (ctl_wr),
        .tick     (tick_w),
        .irq_ack  (irq_ack),
        .irq_pend (irq_pend),
        .dreq     (dreq)
    );

    assign tick = tick_w;
endmodule

// File: rtl/smpt_checker.sv
// Module: smpt_checker
// Temporal properties of the sample period timer, observed at its ports.
// It is attached to every instance of the top by the bind below.
module smpt_checker #(
    parameter int CYC_W = smpt_pkg::CYC_W,
    parameter int CTL_W = smpt_pkg::CTL_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CYC_W-1:0] cyc_cfg,
    input logic [CTL_W-1:0] ctl_cfg,
    input logic             cyc_wr,
    input logic             ctl_wr,
    input logic             irq_ack,
    input logic             tick,
    input logic             irq_pend,
    input logic             dreq
);
    logic unused_chk;
    assign unused_chk = ^{ctl_cfg};

    // A setting of one disables the tick
    AST_NO_TICK_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_cfg == CYC_W'(1)) |-> !tick); // R1

    // No tick in a restart cycle
    AST_NO_TICK_ON_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_wr |-> !tick); // R2

    // Pending only rises after a counted tick
    AST_PEND_RISE_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_pend) |-> $past(tick && !ctl_wr)); // R4

    // A DMA request follows a counted tick with the enable set
    AST_DREQ_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        dreq |-> $past(tick && !ctl_wr && ctl_cfg[smpt_pkg::DMA_BIT])); // R6

    // Pending holds until acknowledged
    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_pend && !irq_ack) |=> irq_pend); // R7

    // Acknowledge without a tick clears pending
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && !tick) |=> !irq_pend); // R8
endmodule

bind smp_tick_irq_div smpt_checker #(.CYC_W(CYC_W), .CTL_W(CTL_W)) i_smpt_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cyc_cfg  (cyc_cfg),
    .ctl_cfg  (ctl_cfg),
    .cyc_wr   (cyc_wr),
    .ctl_wr   (ctl_wr),
    .irq_ack  (irq_ack),
    .tick     (tick),
    .irq_pend (irq_pend),
    .dreq     (dreq)
);

// File: tb/test_smp_tick_irq_div.sv
// Bench: behavioural model of the period timer and divider, compared with
// the outputs in every cycle.
module test_smp_tick_irq_div;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [11:0] cyc_cfg;
    logic [15:0] ctl_cfg;
    logic        cyc_wr, ctl_wr, irq_ack;
    logic        tick, irq_pend, dreq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // model state
    int m_cnt;
    int m_left;
    bit m_pend;
    bit m_dreq;

    always #5 clk = ~clk;

    smp_tick_irq_div i_smp_tick_irq_div (
        .clk(clk), .rst_n(rst_n), .cyc_cfg(cyc_cfg), .ctl_cfg(ctl_cfg),
        .cyc_wr(cyc_wr), .ctl_wr(ctl_wr), .irq_ack(irq_ack),
        .tick(tick), .irq_pend(irq_pend), .dreq(dreq)
    );

    // R3: ratio from bits 11:8, zero means sixteen
    function automatic int ratio_of(input logic [15:0] c);
        int f = int'(c[11:8]);
        return (f == 0) ? 16 : f;
    endfunction

    task automatic cmp(input string req, input logic act, input bit exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
        end
    endtask

    // One cycle: drive at the falling edge, compare, advance the model
    task automatic cycle(input bit rst, input logic [11:0] cyc, input logic [15:0] ctl,
                         input bit cw, input bit tw, input bit ack);
        int  per;
        bit  mt, fire;
        @(negedge clk);
        rst_n = rst; cyc_cfg = cyc; ctl_cfg = ctl;
        cyc_wr = cw; ctl_wr = tw; irq_ack = ack;
        #1;
        per = (int'(cyc) - 1) & 4095;
        if (!rst) begin
            // R9: reset state loaded at the coming edge
            m_cnt = 0; m_left = ratio_of(ctl); m_pend = 0; m_dreq = 0;
            return;
        end
        mt = (per != 0) && !cw && (m_cnt >= per - 1);   // R1, R2
        cmp("R2", tick, mt);
        cmp("R4", irq_pend, m_pend);
        cmp("R6", dreq, m_dreq);
        fire = mt && !tw && (m_left == 1);
        if (cw || per == 0 || mt) m_cnt = 0; else m_cnt++;
        if (tw) m_left = ratio_of(ctl);                  // R5
        else if (mt) m_left = (m_left == 1) ? ratio_of(ctl) : m_left - 1;
        m_dreq = fire && ctl[7];                         // R6
        m_pend = fire || (m_pend && !ack);               // R7, R8
    endtask

    task automatic run(input int n, input logic [11:0] cyc, input logic [15:0] ctl,
                       input int ack_pct);
        for (int i = 0; i < n; i++)
            cycle(1, cyc, ctl, 0, 0, ($urandom % 100) < ack_pct);
    endtask

    initial begin
        logic [15:0] ctl;
        logic [11:0] cyc;
        // R9: reset with period 4, ratio 3, DMA enabled
        ctl = 16'h0380;
        for (int i = 0; i < 3; i++) cycle(0, 12'd5, ctl, 0, 0, 0);
        // R1 R4 R7: no acknowledge, pending must stick
        run(60, 12'd5, ctl, 0);
        // R8: random acknowledges
        run(80, 12'd5, ctl, 30);
        // R2: restart the period mid-count
        cycle(1, 12'd7, ctl, 1, 0, 0);
        run(30, 12'd7, ctl, 20);
        cycle(1, 12'd7, ctl, 1, 0, 0);
        cycle(1, 12'd7, ctl, 0, 0, 1);
        cycle(1, 12'd7, ctl, 1, 0, 0);
        run(20, 12'd7, ctl, 20);
        // R3 R5: field 0 means sixteen ticks
        ctl = 16'h0080;
        cycle(1, 12'd3, ctl, 1, 1, 1);
        run(120, 12'd3, ctl, 10);
        // R1: setting of one disables everything
        cycle(1, 12'd1, ctl, 1, 0, 1);
        run(50, 12'd1, ctl, 0);
        // R5 R8: period one, ratio one, every cycle expires
        ctl = 16'h0180;
        cycle(1, 12'd2, ctl, 1, 1, 0);
        for (int i = 0; i < 200; i++)
            cycle(1, 12'd2, ctl, 0, ($urandom % 4) == 0, ($urandom % 2) == 0);
        // R6: DMA disabled
        ctl = 16'h0200;
        cycle(1, 12'd2, ctl, 0, 1, 1);
        run(60, 12'd2, ctl, 40);
        // soak: random settings and strobes
        for (int i = 0; i < 3000; i++) begin
            if (($urandom % 50) == 0) cyc = 12'(1 + $urandom % 9);
            else cyc = cyc_cfg;
            if (($urandom % 40) == 0) ctl = 16'($urandom);
            cycle(1, cyc, ctl, ($urandom % 60) == 0, ($urandom % 45) == 0,
                  ($urandom % 6) == 0);
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule